// File: doc/BRIEF.md
# Regulator Fault Protection Supervisor

This block is the digital supervisor beside a synchronous buck regulator. It receives comparator decisions already turned into logic levels: feedback below the undervoltage level, above the overvoltage level, and below the crowbar release level, along with two soft-start progress flags, an enable pin and two die-temperature flags. From these it computes the converter enable, the gate-drive permissions and overrides, the enable for a companion linear regulator, and a sticky fault indication.

All asynchronous inputs are synchronised first. The undervoltage and overvoltage levels are then filtered over windows of consecutive clock cycles. A confirmed overvoltage starts a crowbar at once, with the high side held off and the low side held on, until the feedback falls below the release level. The fault latch only accepts undervoltage or overvoltage events once soft-start has passed its lower checkpoint. Over-temperature shutdown restarts by itself, with hysteresis between a trip flag and a cool flag.

Top module: `reg_fault_supervisor`

## Requirements
- R1: Every flag input passes through a two-stage synchroniser, so a change on `en_i` with no fault reaches `conv_en_o` after exactly two rising clock edges.
- R2: With enable high and the lower soft-start flag set, `uv_i` high for 16 consecutive sampled cycles sets `fault_o`. 15 cycles do not set it.
- R3: While the lower soft-start flag is low, `uv_i` has no effect on `fault_o` or `conv_en_o`. Counting starts only once that flag is seen high.
- R4: A single sampled cycle with `uv_i` low restarts the undervoltage count from zero.
- R5: `ov_i` high for 2 consecutive sampled cycles with enable high starts the crowbar: `ls_force_o`=1, `hs_permit_o`=0, `ls_permit_o`=1, `conv_en_o`=0. A single-cycle `ov_i` pulse starts nothing.
- R6: The crowbar holds after `ov_i` falls and ends on the clock edge after the synchronised `fb_low_i` is seen high.
- R7: The crowbar acts while the lower soft-start flag is low, but the fault latch is set only once that flag is later seen high.
- R8: Once `fault_o` is set, it stays set and `conv_en_o` stays 0 until `rst_n` is asserted. With no crowbar active, `hs_permit_o`, `ls_permit_o` and `ls_force_o` are all 0.
- R9: `ot_trip_i` shuts the converter down. It stays down after `ot_trip_i` falls, and restarts only when `ot_cool_i` is seen high with `ot_trip_i` low.
- R10: `ldo_en_o` is 1 only while enable is high, the upper soft-start flag is high, and there is neither a fault nor a thermal shutdown.
- R11: With `en_i` low, `ov_i` does not start a crowbar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low power-on reset; the only way to clear the fault |
| en_i | input | 1 | Regulator enable pin |
| uv_i | input | 1 | Feedback below undervoltage level |
| ov_i | input | 1 | Feedback above overvoltage level |
| fb_low_i | input | 1 | Feedback below crowbar release level |
| ss_lo_i | input | 1 | Soft-start past its lower checkpoint |
| ss_hi_i | input | 1 | Soft-start past its upper checkpoint |
| ot_trip_i | input | 1 | Die temperature above trip point |
| ot_cool_i | input | 1 | Die temperature below restart point |
| conv_en_o | output | 1 | Main converter may switch |
| hs_permit_o | output | 1 | High-side gate may be driven by the modulator |
| ls_permit_o | output | 1 | Low-side gate may be driven |
| ls_force_o | output | 1 | Low-side gate forced on (crowbar) |
| ldo_en_o | output | 1 | Linear regulator enable |
| fault_o | output | 1 | Latched fault |

## Verification
A window counter that is stuck or off by one moves the edge where `fault_o` rises, or where `ls_force_o` rises, by at least one cycle against the fixed latency of synchroniser plus window. The bench pins each of these edges to the exact cycle. A crowbar register that fails to clear keeps `ls_force_o` high one edge past the synchronised release. A thermal state that loses its memory brings `conv_en_o` back while only the trip flag has fallen. A lost pending-overvoltage memory leaves `fault_o` low three edges after the lower soft-start flag rises.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

   typedef struct packed {
      logic en;
      logic uv;
      logic ov;
      logic fb_low;
      logic ss_lo;
      logic ss_hi;
      logic ot_trip;
      logic ot_cool;
   } rsup_flags_t;

   localparam int unsigned FLAG_W = $bits(rsup_flags_t);

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("rsup_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= '0;
               else        stg_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= '0;
               else        stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rsup_persist.sv
module rsup_persist #(
   parameter int unsigned DEPTH = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_i,
   output logic hit_o
);

   generate
      if (DEPTH < 1) begin : g_bad
         $error("rsup_persist: DEPTH must be at least 1");
      end else if (DEPTH == 1) begin : g_direct
         assign hit_o = flag_i;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DEPTH);
         localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            run_q <= '0;
            else if (!flag_i)      run_q <= '0;
            else if (run_q != LAST) run_q <= run_q + 1'b1;
         end

         assign hit_o = flag_i && (run_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/rsup_thermal.sv
module rsup_thermal (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_i,
   input  logic cool_i,
   output logic shut_o
);

   logic shut_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shut_q <= 1'b0;
      else if (trip_i) shut_q <= 1'b1;
      else if (cool_i) shut_q <= 1'b0;
   end

   assign shut_o = shut_q;

endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor
   import rsup_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned UV_WIN      = 16,
   parameter int unsigned OV_WIN      = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic uv_i,
   input  logic ov_i,
   input  logic fb_low_i,
   input  logic ss_lo_i,
   input  logic ss_hi_i,
   input  logic ot_trip_i,
   input  logic ot_cool_i,
   output logic conv_en_o,
   output logic hs_permit_o,
   output logic ls_permit_o,
   output logic ls_force_o,
   output logic ldo_en_o,
   output logic fault_o
);

   generate
      if (UV_WIN < 1 || OV_WIN < 1) begin : g_bad_win
         $error("reg_fault_supervisor: filter windows must be at least 1");
      end
   endgenerate

   rsup_flags_t raw_flags, syn_flags;
   logic [FLAG_W-1:0] syn_vec;

   always_comb begin
      raw_flags.en      = en_i;
      raw_flags.uv      = uv_i;
      raw_flags.ov      = ov_i;
      raw_flags.fb_low  = fb_low_i;
      raw_flags.ss_lo   = ss_lo_i;
      raw_flags.ss_hi   = ss_hi_i;
      raw_flags.ot_trip = ot_trip_i;
      raw_flags.ot_cool = ot_cool_i;
   end

   rsup_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_flags),
      .q_o   (syn_vec)
   );

   assign syn_flags = rsup_flags_t'(syn_vec);

   // flat copies for the bound checker
   logic fb_low_s, ss_hi_s, ss_lo_s;
   assign fb_low_s = syn_flags.fb_low;
   assign ss_hi_s  = syn_flags.ss_hi;
   assign ss_lo_s  = syn_flags.ss_lo;

   logic uv_hit, ov_hit;

   rsup_persist #(.DEPTH(UV_WIN)) uv_filt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (syn_flags.uv && syn_flags.ss_lo && syn_flags.en),
      .hit_o  (uv_hit)
   );

   rsup_persist #(.DEPTH(OV_WIN)) ov_filt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (syn_flags.ov && syn_flags.en),
      .hit_o  (ov_hit)
   );

   logic therm_sd;

   rsup_thermal therm_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .trip_i (syn_flags.ot_trip),
      .cool_i (syn_flags.ot_cool),
      .shut_o (therm_sd)
   );

   logic crowbar_q, ov_seen_q, fault_q, fault_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               crowbar_q <= 1'b0;
      else if (syn_flags.fb_low) crowbar_q <= 1'b0;
      else if (ov_hit)          crowbar_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ov_seen_q <= 1'b0;
      else if (ov_hit) ov_seen_q <= 1'b1;
   end

   assign fault_set = syn_flags.ss_lo && (uv_hit || ov_hit || ov_seen_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fault_q <= 1'b0;
      else if (fault_set) fault_q <= 1'b1;
   end

   logic run_ok;
   assign run_ok = syn_flags.en && !fault_q && !therm_sd;

   assign conv_en_o   = run_ok && !crowbar_q;
   assign hs_permit_o = run_ok && !crowbar_q;
   assign ls_permit_o = (run_ok && !crowbar_q) || crowbar_q;
   assign ls_force_o  = crowbar_q;
   assign ldo_en_o    = run_ok && syn_flags.ss_hi;
   assign fault_o     = fault_q;

endmodule

// File: rtl/rsup_chk.sv
module rsup_chk (
   input logic clk,
   input logic rst_n,
   input logic conv_en,
   input logic hs_permit,
   input logic ls_permit,
   input logic ls_force,
   input logic ldo_en,
   input logic fault,
   input logic fb_low_s,
   input logic ss_hi_s,
   input logic ss_lo_s,
   input logic therm_sd
);

   // R5
   crowbar_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ls_force |-> (!hs_permit && ls_permit && !conv_en));

   // R6
   crowbar_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_force && fb_low_s) |=> !ls_force);

   // R8
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> fault);

   // R8
   fault_stops_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !conv_en);

   // R7
   fault_needs_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> $past(ss_lo_s));

   // R9
   thermal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      therm_sd |-> (!conv_en && !ldo_en));

   // R10
   ldo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ldo_en |-> (ss_hi_s && !fault));

endmodule

bind reg_fault_supervisor rsup_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .conv_en   (conv_en_o),
   .hs_permit (hs_permit_o),
   .ls_permit (ls_permit_o),
   .ls_force  (ls_force_o),
   .ldo_en    (ldo_en_o),
   .fault     (fault_o),
   .fb_low_s  (fb_low_s),
   .ss_hi_s   (ss_hi_s),
   .ss_lo_s   (ss_lo_s),
   .therm_sd  (therm_sd)
);

// File: tb/reg_fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module reg_fault_supervisor_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_i = 0, uv_i = 0, ov_i = 0, fb_low_i = 0;
   logic ss_lo_i = 0, ss_hi_i = 0, ot_trip_i = 0, ot_cool_i = 0;
   logic conv_en_o, hs_permit_o, ls_permit_o, ls_force_o, ldo_en_o, fault_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   reg_fault_supervisor dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .uv_i(uv_i), .ov_i(ov_i),
      .fb_low_i(fb_low_i), .ss_lo_i(ss_lo_i), .ss_hi_i(ss_hi_i),
      .ot_trip_i(ot_trip_i), .ot_cool_i(ot_cool_i),
      .conv_en_o(conv_en_o), .hs_permit_o(hs_permit_o),
      .ls_permit_o(ls_permit_o), .ls_force_o(ls_force_o),
      .ldo_en_o(ldo_en_o), .fault_o(fault_o)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0;
      en_i = 0; uv_i = 0; ov_i = 0; fb_low_i = 0;
      ss_lo_i = 0; ss_hi_i = 0; ot_trip_i = 0; ot_cool_i = 1;
      step(3);
      rst_n = 1;
      step(1);
   endtask

   task automatic startup();
      do_reset();
      en_i = 1; ss_lo_i = 1; ss_hi_i = 1;
      step(4);
   endtask

   task automatic t_reset_and_sync();
      do_reset();
      chk("R8", "fault after reset", fault_o, 1'b0);
      chk("R1", "conv_en after reset", conv_en_o, 1'b0);
      chk("R8", "ls_force after reset", ls_force_o, 1'b0);
      chk("R10", "ldo after reset", ldo_en_o, 1'b0);
      en_i = 1; ss_lo_i = 1;
      step(1);
      chk("R1", "conv_en after one edge", conv_en_o, 1'b0);
      step(1);
      chk("R1", "conv_en after two edges", conv_en_o, 1'b1);
      chk("R1", "hs_permit normal", hs_permit_o, 1'b1);
   endtask

   task automatic t_uv_window();
      startup();
      uv_i = 1;
      step(17);
      chk("R2", "fault after 15 samples", fault_o, 1'b0);
      chk("R2", "conv_en after 15 samples", conv_en_o, 1'b1);
      step(1);
      chk("R2", "fault after 16 samples", fault_o, 1'b1);
      chk("R8", "conv_en when faulted", conv_en_o, 1'b0);
      chk("R8", "hs_permit when faulted", hs_permit_o, 1'b0);
      chk("R8", "ls_permit when faulted", ls_permit_o, 1'b0);
      chk("R8", "ls_force when faulted", ls_force_o, 1'b0);
      uv_i = 0;
      step(10);
      chk("R8", "fault sticky", fault_o, 1'b1);
      chk("R8", "conv_en stays low", conv_en_o, 1'b0);
      do_reset();
      chk("R8", "fault cleared by reset", fault_o, 1'b0);
   endtask

   task automatic t_uv_gated();
      do_reset();
      en_i = 1; ss_lo_i = 0; uv_i = 1;
      step(40);
      chk("R3", "fault with soft-start low", fault_o, 1'b0);
      chk("R3", "conv_en with soft-start low", conv_en_o, 1'b1);
      ss_lo_i = 1;
      step(17);
      chk("R3", "fault before window after soft-start", fault_o, 1'b0);
      step(1);
      chk("R3", "fault after window after soft-start", fault_o, 1'b1);
   endtask

   task automatic t_uv_restart();
      startup();
      uv_i = 1; step(12);
      uv_i = 0; step(1);
      uv_i = 1; step(12);
      chk("R4", "fault after broken runs", fault_o, 1'b0);
      uv_i = 0; step(1);
      uv_i = 1;
      step(17);
      chk("R4", "fault before full fresh run", fault_o, 1'b0);
      step(1);
      chk("R4", "fault after full fresh run", fault_o, 1'b1);
   endtask

   task automatic t_ov_crowbar();
      startup();
      ov_i = 1; step(1);
      ov_i = 0; step(6);
      chk("R5", "single ov pulse", ls_force_o, 1'b0);
      chk("R5", "single ov pulse fault", fault_o, 1'b0);
      ov_i = 1;
      step(3);
      chk("R5", "crowbar before window", ls_force_o, 1'b0);
      step(1);
      chk("R5", "crowbar ls_force", ls_force_o, 1'b1);
      chk("R5", "crowbar hs_permit", hs_permit_o, 1'b0);
      chk("R5", "crowbar ls_permit", ls_permit_o, 1'b1);
      chk("R5", "crowbar conv_en", conv_en_o, 1'b0);
      chk("R7", "fault with soft-start done", fault_o, 1'b1);
      ov_i = 0;
      step(5);
      chk("R6", "crowbar holds after ov falls", ls_force_o, 1'b1);
      fb_low_i = 1;
      step(2);
      chk("R6", "crowbar before release edge", ls_force_o, 1'b1);
      step(1);
      chk("R6", "crowbar released", ls_force_o, 1'b0);
      chk("R8", "ls_permit faulted after crowbar", ls_permit_o, 1'b0);
   endtask

   task automatic t_ov_softstart();
      do_reset();
      en_i = 1; ss_lo_i = 0;
      step(4);
      ov_i = 1;
      step(4);
      chk("R7", "crowbar in soft-start", ls_force_o, 1'b1);
      chk("R7", "no fault in soft-start", fault_o, 1'b0);
      ov_i = 0; fb_low_i = 1;
      step(3);
      chk("R7", "crowbar released in soft-start", ls_force_o, 1'b0);
      fb_low_i = 0;
      step(4);
      chk("R7", "still no fault", fault_o, 1'b0);
      ss_lo_i = 1;
      step(2);
      chk("R7", "fault before soft-start sampled", fault_o, 1'b0);
      step(1);
      chk("R7", "fault after soft-start flag", fault_o, 1'b1);
   endtask

   task automatic t_en_low();
      do_reset();
      ss_lo_i = 1; ss_hi_i = 1; ov_i = 1;
      step(10);
      chk("R11", "no crowbar with enable low", ls_force_o, 1'b0);
      chk("R11", "no fault with enable low", fault_o, 1'b0);
      chk("R10", "ldo off with enable low", ldo_en_o, 1'b0);
   endtask

   task automatic t_ldo();
      do_reset();
      en_i = 1; ss_lo_i = 1; ss_hi_i = 0;
      step(6);
      chk("R10", "ldo before upper flag", ldo_en_o, 1'b0);
      chk("R10", "conv_en before upper flag", conv_en_o, 1'b1);
      ss_hi_i = 1;
      step(1);
      chk("R10", "ldo after one edge", ldo_en_o, 1'b0);
      step(1);
      chk("R10", "ldo after upper flag", ldo_en_o, 1'b1);
   endtask

   task automatic t_thermal();
      startup();
      ot_cool_i = 0; ot_trip_i = 1;
      step(2);
      chk("R9", "conv_en before shutdown edge", conv_en_o, 1'b1);
      step(1);
      chk("R9", "shutdown on trip", conv_en_o, 1'b0);
      chk("R10", "ldo off in shutdown", ldo_en_o, 1'b0);
      ot_trip_i = 0;
      step(8);
      chk("R9", "held between thresholds", conv_en_o, 1'b0);
      ot_cool_i = 1;
      step(2);
      chk("R9", "still held before cool edge", conv_en_o, 1'b0);
      step(1);
      chk("R9", "restart when cool", conv_en_o, 1'b1);
      chk("R9", "no fault from thermal", fault_o, 1'b0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      t_reset_and_sync();
      t_uv_window();
      t_uv_gated();
      t_uv_restart();
      t_ov_crowbar();
      t_ov_softstart();
      t_en_low();
      t_ldo();
      t_thermal();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule